// File: doc/BRIEF.md
# UART Receiver with Error-Tagged Receive Buffer

This block turns an asynchronous serial input into parallel characters. A shared baud generator outside the block supplies a one-cycle enable at sixteen times the bit rate, and the receiver samples the line on that enable. The character length is 5 to 8 bits. Parity can be off, even or odd, and the frame has one or two stop bits. Each finished character is stored together with a three-bit error tag that marks a parity error, a framing error or a break.

The characters go into a receive buffer. After reset the buffer is in single-character mode and holds one entry. A mode write switches it to FIFO mode, where it holds sixteen entries. The read side always shows the oldest entry and its own error tag. A data-ready flag shows that an entry is present. A sticky overrun flag records a character that was lost because the buffer was full. A read pulse removes the head entry and clears the overrun flag.

Top module: `uart_rx_efifo`

## Requirements
- R1: After reset, `data_ready` and `overrun` are 0, `fill_level` is 0 and the buffer is in single-character mode.
- R2: The data length is 5 + `cfg_len` bits (`cfg_len` 0 gives 5 bits, 3 gives 8 bits). Bits arrive LSB first. `rd_data` holds the character right-aligned, and its unused upper bits read 0.
- R3: With `cfg_par_en` set, one parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. `rd_perr` is set when the number of ones in the data plus the parity bit is odd in even mode, or even in odd mode.
- R4: A falling edge is confirmed by sampling the line on the 8th tick after it is seen. If the line is high at that sample, the edge is a false start and nothing is stored.
- R5: Only the first stop bit is sampled. If it reads 0 and the frame is not a break, `rd_ferr` is set. With `cfg_stop2` set, the receiver waits through a second stop bit and does not check it.
- R6: A frame whose start, data, parity and first stop bit all sample 0 is a break. It stores exactly one entry with data 0, `rd_brk`=1, `rd_ferr`=0 and `rd_perr`=0. No further entry is stored until the line is seen high on a tick.
- R7: The buffer holds 1 entry in single-character mode and 16 entries in FIFO mode. Entries are read out in arrival order.
- R8: A character that completes while the buffer is full, with no read in the same cycle, is discarded. The stored entries are kept unchanged and `overrun` is set. `overrun` stays set until an `rd_en` pulse clears it.
- R9: `rd_data` and the three error outputs show the head entry. `rd_en` while `data_ready` is high removes that entry. `rd_en` on an empty buffer leaves `fill_level` at 0.
- R10: A pulse on `mode_wr` loads `mode_fifo` (1 selects FIFO mode). A write that changes the mode empties the buffer. A write that keeps the same mode leaves the contents alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sampling enable at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Two stop bits |
| mode_wr | input | 1 | Mode write strobe |
| mode_fifo | input | 1 | Mode value, 1 = FIFO mode |
| rd_en | input | 1 | Pop head entry, clear overrun |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error tag |
| rd_ferr | output | 1 | Head framing error tag |
| rd_brk | output | 1 | Head break tag |
| data_ready | output | 1 | Buffer not empty |
| overrun | output | 1 | Sticky overrun flag |
| fill_level | output | 5 | Number of stored entries |

## Verification
The bench sweeps every data length, parity mode and stop-bit count. In each configuration one character carries a corrupted parity bit. A design that shifted bits in the wrong direction, aligned short characters wrongly or inverted the parity sense would return wrong data or wrong tags here. The bench also sends a short low glitch, which a design without start-bit confirmation would store as a character. It holds the line low for two frame times, which a design without break handling would store as repeated characters. It fills the buffer one character past capacity in both modes, which a design that overwrites on overrun would expose by corrupting the stored head or the arrival order. Finally it writes the mode both with the same value and with a new value, to catch a design that flushes on every write or never flushes.

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_stop2,
  input  logic          mode_wr,
  input  logic          mode_fifo,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          data_ready,
  output logic          overrun,
  output logic [AW:0]   fill_level
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2, S_BRK} st_t;

  localparam logic [CW-1:0] LAST  = CW'(OSR - 1);
  localparam logic [CW-1:0] MID   = CW'(OSR / 2 - 1);
  localparam logic [AW:0]   CAPF  = (AW + 1)'(DEPTH);

  st_t            st;
  logic [CW-1:0]  tcnt;
  logic [2:0]     bcnt;
  logic [7:0]     sh;
  logic           allz, pacc;
  logic           fmode, ovr;
  logic [AW-1:0]  wp, rp;
  logic [AW:0]    cnt;
  logic [10:0]    mem [DEPTH];

  wire       sample  = tick16 && tcnt == LAST;
  wire       push    = sample && st == S_STOP1;
  wire       is_brk  = !rxd && allz;
  wire [2:0] tag     = {is_brk, !rxd && !allz, cfg_par_en && !is_brk && (pacc ^ cfg_par_odd)};
  wire [7:0] rx_byte = sh >> (2'd3 - cfg_len);
  wire [2:0] last_b  = 3'd4 + {1'b0, cfg_len};

  wire       full    = cnt >= (fmode ? CAPF : (AW + 1)'(1));
  wire       pop     = rd_en && cnt != '0;
  wire       flush   = mode_wr && mode_fifo != fmode;
  wire       accept  = push && (!full || pop) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bcnt <= '0;
      sh   <= '0;
      allz <= 1'b0;
      pacc <= 1'b0;
    end else if (tick16) begin
      tcnt <= tcnt + 1'b1;
      unique case (st)
        S_IDLE: if (!rxd) begin
          st   <= S_START;
          tcnt <= '0;
        end
        S_START: if (tcnt == MID) begin
          tcnt <= '0;
          bcnt <= '0;
          allz <= 1'b1;
          pacc <= 1'b0;
          st   <= rxd ? S_IDLE : S_DATA;
        end
        S_DATA: if (sample) begin
          sh   <= {rxd, sh[7:1]};
          allz <= allz & ~rxd;
          pacc <= pacc ^ rxd;
          bcnt <= bcnt + 1'b1;
          if (bcnt == last_b) st <= cfg_par_en ? S_PAR : S_STOP1;
        end
        S_PAR: if (sample) begin
          allz <= allz & ~rxd;
          pacc <= pacc ^ rxd;
          st   <= S_STOP1;
        end
        S_STOP1: if (sample) begin
          if (is_brk)        st <= S_BRK;
          else if (!rxd)     st <= S_IDLE;
          else if (cfg_stop2) st <= S_STOP2;
          else               st <= S_IDLE;
        end
        S_STOP2: if (sample) st <= S_IDLE;
        S_BRK:   if (rxd)    st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmode <= 1'b0;
      ovr   <= 1'b0;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
    end else begin
      if (mode_wr) fmode <= mode_fifo;
      if (flush) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (accept) wp <= wp + 1'b1;
        if (pop)    rp <= rp + 1'b1;
        cnt <= cnt + (AW + 1)'(accept) - (AW + 1)'(pop);
      end
      if (push && !accept && !flush) ovr <= 1'b1;
      else if (rd_en)                ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk)
    if (accept) mem[wp] <= {tag, rx_byte};

  wire [10:0] head = mem[rp];

  assign data_ready = cnt != '0;
  assign rd_data    = data_ready ? head[7:0] : 8'h00;
  assign rd_perr    = data_ready & head[8];
  assign rd_ferr    = data_ready & head[9];
  assign rd_brk     = data_ready & head[10];
  assign overrun    = ovr;
  assign fill_level = cnt;
endmodule

// File: rtl/uart_rx_efifo_chk.sv
module uart_rx_efifo_chk #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fmode,
  input logic        mode_wr,
  input logic        mode_fifo,
  input logic        rd_en,
  input logic        push,
  input logic [AW:0] fill_level,
  input logic        overrun,
  input logic        data_ready,
  input logic        rd_brk,
  input logic [7:0]  rd_data
);
  a_r7_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !fmode |-> fill_level <= (AW + 1)'(1));

  a_r7_fifo_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= (AW + 1)'(DEPTH));

  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_fifo != fmode) |=> fill_level == '0);

  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(push) && $stable(fill_level));

  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !push) |=> !overrun);

  a_r9_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_ready && !push && !(mode_wr && mode_fifo != fmode))
      |=> fill_level == (AW + 1)'($past(fill_level) - 1'b1));

  a_r6_break_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && rd_brk) |-> rd_data == 8'h00);
endmodule

bind uart_rx_efifo uart_rx_efifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmode(fmode), .mode_wr(mode_wr), .mode_fifo(mode_fifo),
  .rd_en(rd_en), .push(push), .fill_level(fill_level), .overrun(overrun),
  .data_ready(data_ready), .rd_brk(rd_brk), .rd_data(rd_data)
);

// File: tb/uart_rx_efifo_tb.sv
module uart_rx_efifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;
  localparam int BITCLK     = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic mode_wr = 1'b0, mode_fifo = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_perr, rd_ferr, rd_brk, data_ready, overrun;
  logic [4:0] fill_level;
  logic tick16;
  int   tc = 0;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) tc <= (tc == TDIV - 1) ? 0 : tc + 1;
  assign tick16 = (tc == 0);

  uart_rx_efifo u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
    .mode_wr(mode_wr), .mode_fifo(mode_fifo), .rd_en(rd_en), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready),
    .overrun(overrun), .fill_level(fill_level)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  // pm: 0 none, 1 even, 2 odd
  task automatic send(input logic [7:0] d, input int len, input int pm, input bit badp, input logic stopv);
    logic [7:0] m;
    logic p;
    m = 8'hFF >> (3 - len);
    drive_bit(1'b0);
    for (int i = 0; i < 5 + len; i++) drive_bit(d[i]);
    if (pm != 0) begin
      p = ^(d & m);
      if (pm == 2) p = ~p;
      if (badp) p = ~p;
      drive_bit(p);
    end
    drive_bit(stopv);
    if (cfg_stop2) drive_bit(1'b1);
    rxd = 1'b1;
    repeat (BITCLK / 2) @(negedge clk);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic [2:0] t, input string req);
    chk(data_ready == 1'b1, {req, " data_ready"}, data_ready, 1);
    chk(rd_data == d, {req, " data"}, rd_data, d);
    chk({rd_brk, rd_ferr, rd_perr} == t, {req, " tag"}, {rd_brk, rd_ferr, rd_perr}, t);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic v);
    mode_fifo = v;
    mode_wr = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(data_ready == 0, "R1 data_ready", data_ready, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(fill_level == 0, "R1 fill_level", fill_level, 0);
    // R1 single-character mode: two characters, only the first kept
    send(8'h3C, 3, 0, 0, 1'b1);
    send(8'hA5, 3, 0, 0, 1'b1);
    chk(fill_level == 1, "R1 single mode capacity", fill_level, 1);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    pop_expect(8'h3C, 3'b000, "R8 head kept");
    chk(overrun == 0, "R8 overrun cleared", overrun, 0);
    chk(data_ready == 0, "R9 emptied", data_ready, 0);

    // R2 R3 R5 sweep in FIFO mode
    set_mode(1'b1);
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int s = 0; s < 2; s++) begin
          cfg_len = 2'(len);
          cfg_par_en = (pm != 0);
          cfg_par_odd = (pm == 2);
          cfg_stop2 = (s == 1);
          m = 8'hFF >> (3 - len);
          for (int k = 0; k < 3; k++)
            send(8'(k * 73 + len * 29 + pm * 11 + s * 5 + 3), len, pm, (pm != 0 && k == 1), 1'b1);
          chk(fill_level == 3, "R7 fifo holds three", fill_level, 3);
          for (int k = 0; k < 3; k++) begin
            d = 8'(k * 73 + len * 29 + pm * 11 + s * 5 + 3) & m;
            pop_expect(d, {2'b00, (pm != 0 && k == 1)}, "R2 R3 R5 sweep");
          end
        end

    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
    // R5 framing error
    send(8'h55, 3, 0, 0, 1'b0);
    pop_expect(8'h55, 3'b010, "R5 framing");
    // R4 false start
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk(data_ready == 0, "R4 false start ignored", data_ready, 0);
    send(8'h81, 3, 0, 0, 1'b1);
    pop_expect(8'h81, 3'b000, "R4 after glitch");
    // R6 break
    rxd = 1'b0;
    repeat (20 * BITCLK) @(negedge clk);
    chk(fill_level == 1, "R6 single break entry", fill_level, 1);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
    pop_expect(8'h00, 3'b100, "R6 break tag");
    send(8'h42, 3, 0, 0, 1'b1);
    pop_expect(8'h42, 3'b000, "R6 resume");

    // R7 R8 FIFO overflow
    for (int k = 0; k < 17; k++) send(8'(k * 13 + 1), 3, 0, 0, 1'b1);
    chk(fill_level == 16, "R7 fifo full", fill_level, 16);
    chk(overrun == 1, "R8 fifo overrun", overrun, 1);
    for (int k = 0; k < 16; k++) pop_expect(8'(k * 13 + 1), 3'b000, "R7 order");
    chk(overrun == 0, "R8 cleared by read", overrun, 0);
    // R9 read on empty
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(fill_level == 0, "R9 empty read", fill_level, 0);
    // R10 mode writes
    send(8'h11, 3, 0, 0, 1'b1);
    send(8'h22, 3, 0, 0, 1'b1);
    set_mode(1'b1);
    chk(fill_level == 2, "R10 same mode keeps", fill_level, 2);
    pop_expect(8'h11, 3'b000, "R10 contents intact");
    set_mode(1'b0);
    chk(fill_level == 0, "R10 mode change flushes", fill_level, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule